// File: doc/BRIEF.md
# Burst-Limited FIFO Transfer Chunker

This block moves a transfer of N bytes to or from a device's data FIFO as a series of register transactions. Each transaction is at most 64 bytes long. The device limits how much it will accept or supply at a time through a burst-count field in its 32-bit status register. Before every piece of data moves, the block issues a status read to a downstream register-transaction master and extracts that count. A count of zero means the device is busy, and the block simply reads status again. When the count is nonzero, the next chunk is the smallest of three values: the bytes still owed, the reported count, and the 64-byte cap.

Requests to the transaction master use a valid/ready handshake. The master may hold `req_ready` low for any number of cycles. While it does, the block keeps `req_valid` asserted and every request field frozen. After a handshake, the block waits for a one-cycle `rsp_done` pulse, which carries `rsp_err` and, for status reads, `rsp_rdata`. Each request carries a byte offset into an external buffer. The buffer itself, and the serial-bus timing, belong to the master. The block ends a transfer with a one-cycle `done` pulse, or with an `error` pulse if any transaction fails.

Top module: `burst_chunker`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `req_valid` are all low.
- R2: A `start` with `total_len` of zero makes no request. It pulses `done` in the cycle after `start` is sampled, and `busy` stays low.
- R3: Every chunk is preceded by a status request with the following fields:
  - `req_addr` is 0x18.
  - `req_write` is 0.
  - `req_len` is 4.
  - The burst count is taken from bits 23:8 of `rsp_rdata`; all other bits are ignored.
- R4: A burst count of zero causes another status request, and no data request is made in between.
- R5: A data request uses `req_addr` 0x24, and its `req_len` in bytes is min(remaining bytes, burst count, 64).
- R6: With `dir_rx` = 1 the data requests are reads (`req_write` = 0). With `dir_rx` = 0 they are writes (`req_write` = 1). The value of `dir_rx` is captured at `start`.
- R7: The first data request carries `req_offset` 0. Each later one carries the previous offset plus the previous length. `done` pulses in the cycle after the `rsp_done` that completes the total, and `busy` falls in that same cycle.
- R8: An `rsp_err` on any response (status or data) ends the transfer. `error` pulses in the next cycle, `done` is not raised, and no further request is made.
- R9: `req_valid` and all request fields stay stable until `req_ready` is high. No new request is made while a response is still outstanding.
- R10: A `start` that arrives while `busy` is high is ignored. This includes a `start` that arrives in the same cycle as the final `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| total_len | input | LEN_W | Transfer length in bytes |
| dir_rx | input | 1 | 1 = receive from FIFO, 0 = transmit to FIFO |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle abort pulse |
| req_valid | output | 1 | Request offered to transaction master |
| req_ready | input | 1 | Master accepts request |
| req_write | output | 1 | Request is a write |
| req_addr | output | ADDR_W | Register address |
| req_len | output | CH_W | Request length in bytes |
| req_offset | output | LEN_W | Byte offset into external buffer |
| rsp_done | input | 1 | Response pulse for the outstanding request |
| rsp_err | input | 1 | Response reports failure (valid with rsp_done) |
| rsp_rdata | input | 32 | Read data (status word for status reads) |

## Verification
The delicate overlap is the final data response and a fresh `start` arriving in the same cycle. In that cycle the block is still waiting on the bus. It must finish with a single `done` pulse and must not begin a second transfer. The bench drives a `start` with a nonzero length on exactly the edge that carries the last `rsp_done`. It then requires exactly one `done` pulse, followed by several idle cycles with no request and `busy` low. Request back-pressure from a stalling `req_ready`, and a reference model that predicts every request and every output on each clock, decide the remaining cases.

// File: rtl/burst_chunker_pkg.sv
package burst_chunker_pkg;

  typedef enum logic [2:0] {
    BC_IDLE     = 3'd0,
    BC_STS_REQ  = 3'd1,
    BC_STS_WAIT = 3'd2,
    BC_DAT_REQ  = 3'd3,
    BC_DAT_WAIT = 3'd4
  } bc_state_e;

  localparam int unsigned BC_STS_BYTES = 4;

endpackage

// File: rtl/bc_len_sel.sv
module bc_len_sel #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned BURST_LSB = 8,
  parameter int unsigned BURST_W   = 16,
  parameter int unsigned MAX_CHUNK = 64,
  parameter int unsigned CH_W      = $clog2(MAX_CHUNK + 1)
) (
  input  logic [LEN_W-1:0] remaining,
  input  logic [31:0]      status_word,
  output logic             burst_zero,
  output logic [CH_W-1:0]  chunk_len
);

  localparam int unsigned CW = (LEN_W > BURST_W) ? LEN_W : BURST_W;

  logic [BURST_W-1:0] burst;
  logic [CW-1:0]      rem_w, bur_w, cap_w, min_rb, min_all;

  assign burst      = status_word[BURST_LSB +: BURST_W];
  assign burst_zero = (burst == '0);

  assign rem_w = CW'(remaining);
  assign bur_w = CW'(burst);
  assign cap_w = CW'(MAX_CHUNK);

  assign min_rb    = (rem_w < bur_w) ? rem_w : bur_w;
  assign min_all   = (min_rb < cap_w) ? min_rb : cap_w;
  assign chunk_len = min_all[CH_W-1:0];

endmodule

// File: rtl/bc_progress.sv
module bc_progress #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CH_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CH_W-1:0]  chunk_in,
  input  logic             advance,
  input  logic [LEN_W-1:0] total,
  output logic [LEN_W-1:0] offset,
  output logic [CH_W-1:0]  chunk,
  output logic [LEN_W-1:0] remaining,
  output logic             last
);

  logic [LEN_W:0] next_sum;

  assign next_sum  = {1'b0, offset} + (LEN_W + 1)'(chunk);
  assign remaining = total - offset;
  assign last      = (next_sum == {1'b0, total});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
      chunk  <= '0;
    end else if (clear) begin
      offset <= '0;
      chunk  <= '0;
    end else begin
      if (load)    chunk  <= chunk_in;
      if (advance) offset <= next_sum[LEN_W-1:0];
    end
  end

endmodule

// File: rtl/burst_chunker.sv
module burst_chunker
  import burst_chunker_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned MAX_CHUNK = 64,
  parameter int unsigned BURST_LSB = 8,
  parameter int unsigned BURST_W   = 16,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 24'h000018,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 24'h000024,
  parameter int unsigned CH_W      = $clog2(MAX_CHUNK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  total_len,
  input  logic              dir_rx,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CH_W-1:0]   req_len,
  output logic [LEN_W-1:0]  req_offset,
  input  logic              rsp_done,
  input  logic              rsp_err,
  input  logic [31:0]       rsp_rdata
);

  bc_state_e        state_q;
  logic [LEN_W-1:0] total_q;
  logic             dir_q;
  logic             done_q, err_q;

  logic             clr_prog, load_chunk, adv_off;
  logic [LEN_W-1:0] offset, remaining;
  logic [CH_W-1:0]  chunk_q, chunk_new;
  logic             last_chunk, burst_zero;

  bc_len_sel #(
    .LEN_W(LEN_W), .BURST_LSB(BURST_LSB), .BURST_W(BURST_W),
    .MAX_CHUNK(MAX_CHUNK), .CH_W(CH_W)
  ) u_len_sel (
    .remaining  (remaining),
    .status_word(rsp_rdata),
    .burst_zero (burst_zero),
    .chunk_len  (chunk_new)
  );

  bc_progress #(.LEN_W(LEN_W), .CH_W(CH_W)) u_progress (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clr_prog),
    .load     (load_chunk),
    .chunk_in (chunk_new),
    .advance  (adv_off),
    .total    (total_q),
    .offset   (offset),
    .chunk    (chunk_q),
    .remaining(remaining),
    .last     (last_chunk)
  );

  assign clr_prog   = (state_q == BC_IDLE) && start;
  assign load_chunk = (state_q == BC_STS_WAIT) && rsp_done && !rsp_err && !burst_zero;
  assign adv_off    = (state_q == BC_DAT_WAIT) && rsp_done && !rsp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BC_IDLE;
      total_q <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        BC_IDLE: begin
          if (start) begin
            total_q <= total_len;
            dir_q   <= dir_rx;
            if (total_len == '0) done_q  <= 1'b1;
            else                 state_q <= BC_STS_REQ;
          end
        end
        BC_STS_REQ: begin
          if (req_ready) state_q <= BC_STS_WAIT;
        end
        BC_STS_WAIT: begin
          if (rsp_done) begin
            if (rsp_err) begin
              err_q   <= 1'b1;
              state_q <= BC_IDLE;
            end else if (burst_zero) begin
              state_q <= BC_STS_REQ;
            end else begin
              state_q <= BC_DAT_REQ;
            end
          end
        end
        BC_DAT_REQ: begin
          if (req_ready) state_q <= BC_DAT_WAIT;
        end
        BC_DAT_WAIT: begin
          if (rsp_done) begin
            if (rsp_err) begin
              err_q   <= 1'b1;
              state_q <= BC_IDLE;
            end else if (last_chunk) begin
              done_q  <= 1'b1;
              state_q <= BC_IDLE;
            end else begin
              state_q <= BC_STS_REQ;
            end
          end
        end
        default: state_q <= BC_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != BC_IDLE);
  assign done       = done_q;
  assign error      = err_q;
  assign req_valid  = (state_q == BC_STS_REQ) || (state_q == BC_DAT_REQ);
  assign req_write  = (state_q == BC_DAT_REQ) && !dir_q;
  assign req_addr   = (state_q == BC_DAT_REQ) ? FIFO_ADDR : STS_ADDR;
  assign req_len    = (state_q == BC_DAT_REQ) ? chunk_q : CH_W'(BC_STS_BYTES);
  assign req_offset = offset;

endmodule

// File: rtl/burst_chunker_chk.sv
module burst_chunker_chk #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned MAX_CHUNK = 64,
  parameter logic [ADDR_W-1:0] STS_ADDR = 24'h000018,
  parameter int unsigned CH_W      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CH_W-1:0]   req_len,
  input logic [LEN_W-1:0]  req_offset
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len)
                                && $stable(req_write) && $stable(req_offset));

  // R5
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= CH_W'(MAX_CHUNK)));

  // R3
  sts_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_addr == STS_ADDR) |-> !req_write && (req_len == CH_W'(4)));

  // R8
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !req_valid && !busy);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done || error);

endmodule

bind burst_chunker burst_chunker_chk #(
  .LEN_W(LEN_W), .ADDR_W(ADDR_W), .MAX_CHUNK(MAX_CHUNK),
  .STS_ADDR(STS_ADDR), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .error(error), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
  .req_offset(req_offset)
);

// File: tb/burst_chunker_tb.sv
module burst_chunker_tb;

  localparam int LEN_W = 16;
  localparam int ADDR_W = 24;
  localparam int CH_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] total_len = '0;
  logic dir_rx = 1'b0;
  logic busy, done, error, req_valid, req_write;
  logic req_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [CH_W-1:0] req_len;
  logic [LEN_W-1:0] req_offset;
  logic rsp_done = 1'b0;
  logic rsp_err = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int bq[$];
  bit finished = 0;

  always #10 clk = ~clk;

  burst_chunker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .dir_rx(dir_rx), .busy(busy), .done(done), .error(error),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_offset(req_offset),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic run_xfer(input int len, input bit rx, input int err_at, input bit collide);
    int e_addr[$], e_wr[$], e_len[$], e_off[$], e_b[$];
    int rem, off, idx, bi, nreq, k, r, cnt;
    bit aborted, out, e_done, e_err, e_busy, ended;
    string tag;
    rem = len; off = 0; idx = 0; bi = 0; aborted = 0;
    while (rem > 0 && !aborted) begin
      int b, c;
      b = bq[bi]; bi++;
      e_addr.push_back(24); e_wr.push_back(0); e_len.push_back(4);
      e_off.push_back(-1); e_b.push_back(b);
      if (idx == err_at) aborted = 1;
      idx++;
      if (!aborted && b != 0) begin
        c = rem; if (b < c) c = b; if (64 < c) c = 64;
        e_addr.push_back(36); e_wr.push_back(rx ? 0 : 1); e_len.push_back(c);
        e_off.push_back(off); e_b.push_back(-1);
        if (idx == err_at) aborted = 1;
        idx++;
        off += c; rem -= c;
      end
    end
    nreq = e_addr.size();
    @(negedge clk);
    start = 1'b1; total_len = LEN_W'(len); dir_rx = rx;
    e_done = (len == 0); e_err = 0; e_busy = (len != 0);
    k = 0; r = 0; cnt = 0; out = 0; ended = 0;
    tag = (len == 0) ? "R2" : "R7";
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      chk(done == e_done && error == e_err && busy == e_busy,
          e_err ? "R8" : tag,
          $sformatf("done/error/busy=%0b%0b%0b expected %0b%0b%0b",
                    done, error, busy, e_done, e_err, e_busy));
      if (e_done || e_err) begin ended = 1; break; end
      rsp_done = 1'b0; rsp_err = 1'b0;
      if (out) begin
        req_ready = 1'b0;
        if (req_valid) chk(0, "R9", "actual req_valid=1 while response outstanding, expected 0");
        cnt--;
        if (cnt == 0) begin
          out = 0;
          rsp_done = 1'b1;
          rsp_err = (r == err_at);
          rsp_rdata = (e_b[r] >= 0) ? {8'hC3, 16'(e_b[r]), 8'h7E} : 32'hFFFF_FFFF;
          if (r == nreq - 1) begin
            if (r == err_at) e_err = 1; else e_done = 1;
            e_busy = 0;
            if (collide) begin start = 1'b1; total_len = 9; dir_rx = 1'b0; end
          end
        end
      end else begin
        req_ready = ((cyc % 3) != 1);
        if (req_valid && req_ready) begin
          if (k >= nreq) begin
            chk(0, "R10", $sformatf("actual extra request addr=%0h, expected none", req_addr));
          end else begin
            chk(int'(req_addr) == e_addr[k], (e_addr[k] == 24) ? "R3" : "R5",
                $sformatf("req %0d addr actual %0h expected %0h", k, req_addr, e_addr[k]));
            chk(int'(req_len) == e_len[k], (e_addr[k] == 24) ? "R4" : "R5",
                $sformatf("req %0d len actual %0d expected %0d", k, req_len, e_len[k]));
            chk(int'(req_write) == e_wr[k], "R6",
                $sformatf("req %0d write actual %0b expected %0d", k, req_write, e_wr[k]));
            if (e_off[k] >= 0)
              chk(int'(req_offset) == e_off[k], "R7",
                  $sformatf("req %0d offset actual %0d expected %0d", k, req_offset, e_off[k]));
            r = k; k++; out = 1; cnt = 1 + (cyc % 2);
          end
        end
      end
    end
    if (!ended) chk(0, "R7", "actual no completion, expected done or error");
    rsp_done = 1'b0; rsp_err = 1'b0; req_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk(!req_valid && !busy && !done && !error, collide ? "R10" : "R8",
          $sformatf("idle after end: valid/busy/done/error=%0b%0b%0b%0b expected 0000",
                    req_valid, busy, done, error));
    end
    req_ready = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error && !req_valid, "R1",
        $sformatf("busy/done/error/valid=%0b%0b%0b%0b expected 0000",
                  busy, done, error, req_valid));
    // R2 zero length
    bq = {5}; run_xfer(0, 0, -1, 0);
    // R5 remaining bytes smallest, R6 transmit
    bq = {20}; run_xfer(10, 0, -1, 0);
    // R5 64-byte cap, R6 receive
    bq = {100, 100, 100, 100}; run_xfer(150, 1, -1, 0);
    // R4 zero burst re-poll, R5 burst smallest
    bq = {0, 0, 8, 5, 0, 40, 40}; run_xfer(30, 0, -1, 0);
    // R8 error on a data response
    bq = {10, 10, 10, 10, 10, 10}; run_xfer(50, 1, 3, 0);
    // R8 error on a status response
    bq = {10, 10, 10}; run_xfer(20, 0, 0, 0);
    // R7 single-byte chunks
    bq = {1, 1, 1, 1}; run_xfer(3, 1, -1, 0);
    // R10 start coinciding with final response
    bq = {12, 12}; run_xfer(12, 0, -1, 1);
    // R3 recovery transfer after collision
    bq = {64, 64}; run_xfer(64, 1, -1, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule